// File: doc/BRIEF.md
# Board Interrupt Hub

This block sits on a 16-bit host bus and gathers thirty-two level-sensitive peripheral interrupt requests into one active-low summary line for the host. The requests are split across two 16-bit halves. Each half has a status register that mirrors the request levels and a mask register in which a set bit blocks the matching source. The summary line stays asserted for as long as any status bit whose mask bit is clear remains set. Software services a source and then waits for the peripheral to drop its request. No clear-on-read or write-to-clear behaviour exists.

The same register window also carries a few board-control functions:
- two device-reset registers whose set bits produce self-clearing pulses on the reset outputs;
- a backlight enable;
- a read-only revision word made from two board revision inputs;
- a read-only word carrying three clock-mode strap pins;
- four read-only switch-bank words.

Accesses are single-cycle. A write takes effect at the clock edge on which select and write are both high. Read data is valid in the same cycle as a read access.

Top module: `board_irq_hub`

## Requirements
- R1: After reset, both mask registers read 0xFFFF, the summary line irqN is high, devRst is all zero and backlightOn is low.
- R2: Status is read-only. Offset 0x0022 returns the levels of sources 31..16 and offset 0x0020 returns sources 15..0, each sampled one clock after the request. Writes to either offset change nothing.
- R3: The mask registers are read/write at 0x0030 (sources 15..0) and 0x0032 (sources 31..16). Source n is controlled by bit n mod 16 of half n/16.
- R4: irqN is low exactly when some status bit is set while its mask bit is 0. A mask bit of 1 blocks its source. The Ethernet request is source 15, bit 15 at 0x0030.
- R5: irqN is a level output with two clocks of latency from a request change: one clock to capture status and one to register the line. It returns high once every unmasked request has dropped.
- R6: Device-reset registers sit at 0x10D0 (driving devRst[15:0]) and 0x10D2 (driving devRst[31:16]); bit 2 of 0x10D0 is the Ethernet reset. A write ORs the written 1s into the register and restarts a 16-cycle timer. The bits stay high for 16 cycles after the write edge and then clear together. The registers read back their current value.
- R7: Bit 0 of 0x10B4 drives backlightOn (1 means on) and reads back. The other bits read 0.
- R8: Offset 0x1100 reads {cpuRev, baseRev}, with cpuRev in bits 15:8.
- R9: Offset 0x10E0 reads clkStrap in bits 10:8 and 0 in every other bit.
- R10: Offsets 0x0070, 0x0072, 0x0074 and 0x0076 read swBank[15:0], [31:16], [47:32] and [63:48] respectively.
- R11: Any other offset, including every odd offset, reads 0x0000, and a write to it changes no register or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access select |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | 13 | Byte offset into the register window |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data; 0 when no mapped read is selected |
| irqReq | input | 32 | Level interrupt requests, active-high |
| swBank | input | 64 | Four 16-bit switch-bank words |
| clkStrap | input | 3 | Clock-mode strap pins |
| cpuRev | input | 8 | Processor board revision |
| baseRev | input | 8 | Base board revision |
| irqN | output | 1 | Combined interrupt, active-low, level |
| devRst | output | 32 | Device reset pulses, active-high |
| backlightOn | output | 1 | Backlight enable |

## Verification
The assertions rely on three properties of the inputs:
- irqReq is synchronous to clk, so that each request level is captured exactly once per edge.
- busWr only has meaning while busSel is high.
- The bus inputs stay idle during reset.

The stimulus meets these conditions by changing every input only on the falling clock edge, holding the bus deselected through reset, and dropping select half a cycle after each read. Request patterns are applied while the line is masked, so the two-cycle capture path is always observed from a known quiet state.

// File: rtl/board_irq_pkg.sv
package board_irq_pkg;

  localparam int HALF_W    = 16;
  localparam int NUM_HALF  = 2;
  localparam int SRC_N     = HALF_W * NUM_HALF;
  localparam int ADDR_W    = 13;
  localparam int SW_BANKS  = 4;
  localparam int RST_REGS  = 2;
  localparam int REV_W     = 8;
  localparam int STRAP_W   = 3;
  localparam int STRAP_LSB = 8;
  localparam int IDX_W     = 2;
  localparam int HIDX_W    = (NUM_HALF > 1) ? $clog2(NUM_HALF) : 1;
  localparam int RIDX_W    = (RST_REGS > 1) ? $clog2(RST_REGS) : 1;

  localparam logic [ADDR_W-1:0] OFS_STAT  = 13'h0020;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 13'h0030;
  localparam logic [ADDR_W-1:0] OFS_SW    = 13'h0070;
  localparam logic [ADDR_W-1:0] OFS_LIGHT = 13'h10B4;
  localparam logic [ADDR_W-1:0] OFS_RST   = 13'h10D0;
  localparam logic [ADDR_W-1:0] OFS_STRAP = 13'h10E0;
  localparam logic [ADDR_W-1:0] OFS_VER   = 13'h1100;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_STAT  = 3'd1,
    SEL_MASK  = 3'd2,
    SEL_SW    = 3'd3,
    SEL_RST   = 3'd4,
    SEL_LIGHT = 3'd5,
    SEL_STRAP = 3'd6,
    SEL_VER   = 3'd7
  } regSel_e;

  typedef struct packed {
    logic [NUM_HALF-1:0] wrMask;
    logic [RST_REGS-1:0] wrRst;
    logic                wrLight;
    regSel_e             rdSel;
    logic [IDX_W-1:0]    idx;
  } ctrlStrobe_t;

endpackage

// File: rtl/board_irq_ctrl.sv
module board_irq_ctrl
  import board_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strb
);

  logic rdEn;
  logic wrEn;
  logic [NUM_HALF-1:0] statHit;
  logic [NUM_HALF-1:0] maskHit;
  logic [SW_BANKS-1:0] swHit;
  logic [RST_REGS-1:0] rstHit;
  logic lightHit;
  logic strapHit;
  logic verHit;

  assign rdEn = busSel & ~busWr;
  assign wrEn = busSel & busWr;

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_halfHit
    assign statHit[h] = (busAddr == OFS_STAT + ADDR_W'(2 * h));
    assign maskHit[h] = (busAddr == OFS_MASK + ADDR_W'(2 * h));
  end

  for (genvar k = 0; k < SW_BANKS; k++) begin : g_swHit
    assign swHit[k] = (busAddr == OFS_SW + ADDR_W'(2 * k));
  end

  for (genvar r = 0; r < RST_REGS; r++) begin : g_rstHit
    assign rstHit[r] = (busAddr == OFS_RST + ADDR_W'(2 * r));
  end

  assign lightHit = (busAddr == OFS_LIGHT);
  assign strapHit = (busAddr == OFS_STRAP);
  assign verHit   = (busAddr == OFS_VER);

  always_comb begin
    strb = '0;
    for (int h = 0; h < NUM_HALF; h++) begin
      if (statHit[h] && rdEn) begin
        strb.rdSel = SEL_STAT;
        strb.idx   = IDX_W'(h);
      end
      if (maskHit[h]) begin
        strb.wrMask[h] = wrEn;
        if (rdEn) begin
          strb.rdSel = SEL_MASK;
          strb.idx   = IDX_W'(h);
        end
      end
    end
    for (int k = 0; k < SW_BANKS; k++) begin
      if (swHit[k] && rdEn) begin
        strb.rdSel = SEL_SW;
        strb.idx   = IDX_W'(k);
      end
    end
    for (int r = 0; r < RST_REGS; r++) begin
      if (rstHit[r]) begin
        strb.wrRst[r] = wrEn;
        if (rdEn) begin
          strb.rdSel = SEL_RST;
          strb.idx   = IDX_W'(r);
        end
      end
    end
    if (lightHit) begin
      strb.wrLight = wrEn;
      if (rdEn) strb.rdSel = SEL_LIGHT;
    end
    if (strapHit && rdEn) strb.rdSel = SEL_STRAP;
    if (verHit && rdEn)   strb.rdSel = SEL_VER;
  end

  // R11
  odd_offset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busAddr[0]) |-> (strb.rdSel == SEL_NONE && strb.wrMask == '0 &&
                                strb.wrRst == '0 && !strb.wrLight))
    else $error("odd offset produced an access strobe");

  // R2
  status_readonly_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && (busAddr == OFS_STAT || busAddr == OFS_STAT + ADDR_W'(2)))
      |-> (strb.wrMask == '0 && strb.wrRst == '0 && !strb.wrLight))
    else $error("status write produced a write strobe");

  // R11
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> (strb.rdSel == SEL_NONE && strb.wrMask == '0 && strb.wrRst == '0))
    else $error("strobe without select");

endmodule

// File: rtl/board_irq_datapath.sv
module board_irq_datapath
  import board_irq_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strb,
  input  logic [HALF_W-1:0]      busWdata,
  input  logic [SRC_N-1:0]       irqReq,
  input  logic [SW_BANKS*HALF_W-1:0] swBank,
  input  logic [STRAP_W-1:0]     clkStrap,
  input  logic [REV_W-1:0]       cpuRev,
  input  logic [REV_W-1:0]       baseRev,
  output logic [HALF_W-1:0]      busRdata,
  output logic                   irqN,
  output logic [RST_REGS*HALF_W-1:0] devRst,
  output logic                   backlightOn
);

  localparam int CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam int RUN_W = CNT_W + 1;

  logic [NUM_HALF-1:0][HALF_W-1:0] statQ;
  logic [NUM_HALF-1:0][HALF_W-1:0] maskQ;
  logic [RST_REGS-1:0][HALF_W-1:0] rstQ;
  logic [RST_REGS-1:0][CNT_W-1:0]  rstCnt;
  logic [SRC_N-1:0]                pendVec;
  logic                            irqQ;
  logic                            lightQ;

  // status capture and mask registers, one pair per half
  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rstN) begin
        statQ[h] <= '0;
        maskQ[h] <= '1;
      end else begin
        statQ[h] <= irqReq[h*HALF_W +: HALF_W];
        if (strb.wrMask[h]) maskQ[h] <= busWdata;
      end
    end

    assign pendVec[h*HALF_W +: HALF_W] = statQ[h] & ~maskQ[h];

    // R3
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$past(strb.wrMask[h]) |-> $stable(maskQ[h]))
      else $error("mask half changed without a write");
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b1;
    else       irqQ <= ~(|pendVec);
  end

  assign irqN = irqQ;

  // device reset registers with self-clearing timer
  for (genvar r = 0; r < RST_REGS; r++) begin : g_rst
    logic [RUN_W-1:0] runCnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rstQ[r]   <= '0;
        rstCnt[r] <= '0;
      end else if (strb.wrRst[r]) begin
        rstQ[r]   <= rstQ[r] | busWdata;
        rstCnt[r] <= CNT_W'(PULSE_LEN - 1);
      end else if (rstQ[r] != '0) begin
        if (rstCnt[r] == '0) rstQ[r] <= '0;
        else                 rstCnt[r] <= rstCnt[r] - 1'b1;
      end
    end

    assign devRst[r*HALF_W +: HALF_W] = rstQ[r];

    always_ff @(posedge clk) begin
      if (!rstN)                runCnt <= '0;
      else if (strb.wrRst[r])   runCnt <= '0;
      else if (rstQ[r] != '0)   runCnt <= runCnt + 1'b1;
      else                      runCnt <= '0;
    end

    // R6
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
      (rstQ[r] != '0) |-> (runCnt < RUN_W'(PULSE_LEN)))
      else $error("reset pulse outlived its window");

    // R6
    pulse_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(|rstQ[r]) |-> $past(strb.wrRst[r]))
      else $error("reset pulse started without a write");
  end

  always_ff @(posedge clk) begin
    if (!rstN)             lightQ <= 1'b0;
    else if (strb.wrLight) lightQ <= busWdata[0];
  end

  assign backlightOn = lightQ;

  always_comb begin
    busRdata = '0;
    case (strb.rdSel)
      SEL_STAT:  busRdata = statQ[strb.idx[HIDX_W-1:0]];
      SEL_MASK:  busRdata = maskQ[strb.idx[HIDX_W-1:0]];
      SEL_SW:    busRdata = swBank[HALF_W*int'(strb.idx) +: HALF_W];
      SEL_RST:   busRdata = rstQ[strb.idx[RIDX_W-1:0]];
      SEL_LIGHT: busRdata = {{(HALF_W-1){1'b0}}, lightQ};
      SEL_STRAP: busRdata[STRAP_LSB +: STRAP_W] = clkStrap;
      SEL_VER:   busRdata = {cpuRev, baseRev};
      default:   busRdata = '0;
    endcase
  end

  // R4
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&$past(maskQ)) |-> irqN)
    else $error("summary line low while every source masked");

  // R5
  level_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(irqReq, 2) == '0) |-> irqN)
    else $error("summary line low with no request two cycles earlier");

  // R7
  light_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.wrLight) |-> $stable(lightQ))
    else $error("backlight changed without a write");

endmodule

// File: rtl/board_irq_hub.sv
module board_irq_hub
  import board_irq_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busSel,
  input  logic                       busWr,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [HALF_W-1:0]          busWdata,
  output logic [HALF_W-1:0]          busRdata,
  input  logic [SRC_N-1:0]           irqReq,
  input  logic [SW_BANKS*HALF_W-1:0] swBank,
  input  logic [STRAP_W-1:0]         clkStrap,
  input  logic [REV_W-1:0]           cpuRev,
  input  logic [REV_W-1:0]           baseRev,
  output logic                       irqN,
  output logic [RST_REGS*HALF_W-1:0] devRst,
  output logic                       backlightOn
);

  ctrlStrobe_t strb;

  board_irq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strb    (strb)
  );

  board_irq_datapath #(
    .PULSE_LEN (PULSE_LEN)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .busWdata    (busWdata),
    .irqReq      (irqReq),
    .swBank      (swBank),
    .clkStrap    (clkStrap),
    .cpuRev      (cpuRev),
    .baseRev     (baseRev),
    .busRdata    (busRdata),
    .irqN        (irqN),
    .devRst      (devRst),
    .backlightOn (backlightOn)
  );

endmodule

// File: tb/board_irq_hub_bench.sv
module board_irq_hub_bench;
  import board_irq_pkg::*;

  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busSel;
  logic        busWr;
  logic [ADDR_W-1:0] busAddr;
  logic [15:0] busWdata;
  logic [15:0] busRdata;
  logic [31:0] irqReq;
  logic [63:0] swBank;
  logic [2:0]  clkStrap;
  logic [7:0]  cpuRev;
  logic [7:0]  baseRev;
  logic        irqN;
  logic [31:0] devRst;
  logic        backlightOn;

  typedef struct {
    int          kind;   // 0 read data, 1 irqN, 2 devRst, 3 backlightOn
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sb[$];
  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;

  always #(CLK_NS/2) clk = ~clk;

  board_irq_hub u_board_irq_hub (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqReq(irqReq), .swBank(swBank),
    .clkStrap(clkStrap), .cpuRev(cpuRev), .baseRev(baseRev), .irqN(irqN),
    .devRst(devRst), .backlightOn(backlightOn)
  );

  // monitor: compares queued expectations shortly after each falling edge
  initial begin
    item_t it;
    logic [31:0] act;
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        it = sb.pop_front();
        case (it.kind)
          0:       act = {16'h0, busRdata};
          1:       act = {31'h0, irqN};
          2:       act = devRst;
          default: act = {31'h0, backlightOn};
        endcase
        compared++;
        if (act !== it.exp) begin
          mismatched++;
          $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rdChk(input logic [ADDR_W-1:0] a, input logic [15:0] e, input string r);
    @(negedge clk);
    busSel  = 1'b1;
    busWr   = 1'b0;
    busAddr = a;
    sb.push_back('{0, {16'h0, e}, r});
    #3;
    busSel  = 1'b0;
  endtask

  task automatic portChk(input int kind, input logic [31:0] e, input string r);
    @(negedge clk);
    sb.push_back('{kind, e, r});
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel   = 1'b1;
    busWr    = 1'b1;
    busAddr  = a;
    busWdata = d;
    @(negedge clk);
    busSel   = 1'b0;
    busWr    = 1'b0;
  endtask

  task automatic setReq(input logic [31:0] v);
    @(negedge clk);
    irqReq = v;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; busSel = 1'b0; busWr = 1'b0; busAddr = '0; busWdata = '0;
    irqReq = '0; swBank = 64'h4444_3333_2222_1111; clkStrap = 3'b101;
    cpuRev = 8'h5A; baseRev = 8'h3C;
    idle(5);
    rstN = 1'b1;

    // R1 reset state
    rdChk(13'h0030, 16'hFFFF, "R1 mask low after reset");
    rdChk(13'h0032, 16'hFFFF, "R1 mask high after reset");
    portChk(1, 32'h1, "R1 irqN after reset");
    portChk(2, 32'h0, "R1 devRst after reset");
    portChk(3, 32'h0, "R1 backlight after reset");

    // R2 status, R4 masked sources stay quiet
    setReq(32'h8000_8001);
    idle(2);
    portChk(1, 32'h1, "R4 all sources masked");
    rdChk(13'h0020, 16'h8001, "R2 status low");
    rdChk(13'h0022, 16'h8000, "R2 status high");
    wr(13'h0020, 16'h0000);
    rdChk(13'h0020, 16'h8001, "R2 status ignores write");

    // R4 ethernet source 15 unmasked
    wr(13'h0030, 16'h7FFF);
    portChk(1, 32'h0, "R4 source 15 unmasked");
    rdChk(13'h0030, 16'h7FFF, "R3 mask low readback");

    // R5 release and exact latency
    setReq(32'h8000_0001);
    idle(2);
    portChk(1, 32'h1, "R5 released after request drop");
    setReq(32'h8000_8001);
    portChk(1, 32'h1, "R5 one cycle after request");
    portChk(1, 32'h0, "R5 two cycles after request");
    setReq(32'h0000_0000);
    idle(3);

    // R3 source 16 in high half bit 0
    setReq(32'h0001_0000);
    wr(13'h0032, 16'hFFFE);
    portChk(1, 32'h0, "R3 source 16 via high mask bit 0");
    rdChk(13'h0032, 16'hFFFE, "R3 mask high readback");
    wr(13'h0032, 16'hFFFF);
    portChk(1, 32'h1, "R4 source re-masked");
    setReq(32'h0);
    idle(3);

    // R6 ethernet reset pulse
    wr(13'h10D0, 16'h0004);
    rdChk(13'h10D0, 16'h0004, "R6 reset low readback");
    for (int k = 2; k <= 15; k++) portChk(2, 32'h0000_0004, "R6 ethernet reset held");
    portChk(2, 32'h0, "R6 reset cleared after 16 cycles");
    wr(13'h10D2, 16'h0003);
    portChk(2, 32'h0003_0000, "R6 second reset register");
    rdChk(13'h10D2, 16'h0003, "R6 reset high readback");
    idle(16);
    portChk(2, 32'h0, "R6 second register cleared");
    rdChk(13'h10D2, 16'h0000, "R6 readback after clear");

    // R7 backlight
    wr(13'h10B4, 16'hFFFF);
    portChk(3, 32'h1, "R7 backlight on");
    rdChk(13'h10B4, 16'h0001, "R7 backlight readback");
    wr(13'h10B4, 16'h0000);
    portChk(3, 32'h0, "R7 backlight off");

    // R8, R9, R10 read-only words
    rdChk(13'h1100, 16'h5A3C, "R8 revision word");
    rdChk(13'h10E0, 16'h0500, "R9 strap bits");
    rdChk(13'h0070, 16'h1111, "R10 switch bank 0");
    rdChk(13'h0072, 16'h2222, "R10 switch bank 1");
    rdChk(13'h0074, 16'h3333, "R10 switch bank 2");
    rdChk(13'h0076, 16'h4444, "R10 switch bank 3");

    // R11 unmapped offsets
    rdChk(13'h0024, 16'h0000, "R11 unmapped read");
    rdChk(13'h0021, 16'h0000, "R11 odd offset read");
    wr(13'h0031, 16'h0000);
    wr(13'h1234, 16'hFFFF);
    wr(13'h10B5, 16'h0001);
    rdChk(13'h0030, 16'h7FFF, "R11 mask untouched by odd write");
    portChk(3, 32'h0, "R11 backlight untouched");
    portChk(2, 32'h0, "R11 resets untouched");
    rdChk(13'h1234, 16'h0000, "R11 unmapped readback");

    idle(3);
    finished = 1;
    summary();
    $finish;
  end

endmodule